// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block joins two eight-bit buses, called A and B, and can move data across in either direction. Each direction has a capture register on its own clock. A select input picks what reaches the far bus: either the live value of the source bus, or the word that the direction's register holds. The value driven onto a bus is always the bit-wise complement of the chosen source.

Each bus pad is split into three signals: an input, a data output and an output enable. Tristate wiring stays outside the block. The enable for the B side is active high and the enable for the A side is active low. With the A side disabled and the B side enabled, only B is driven. With both disabled, the two buses are isolated. With both enabled, the held words can be swapped across both buses at once.

A capture register samples its bus input on every rising edge of its clock, whatever the select and enable pins are doing. A bus that the block itself drives is therefore stored as the value seen on its pad.

Top module: `xbus_regxcvr`

## Requirements
- R1: On every rising edge of `clk_ab` with `rst` low, the A-to-B register loads `a_in`, whatever the values of `en_b`, `en_a_n`, `sel_ab` and `sel_ba`.
- R2: On every rising edge of `clk_ba` with `rst` low, the B-to-A register loads `b_in`, whatever the values of the select and enable inputs.
- R3: While `sel_ab` is 0, `b_out` equals the bit-wise inverse of `a_in`, with no clock involved.
- R4: While `sel_ab` is 1, `b_out` equals the bit-wise inverse of the A-to-B register.
- R5: While `sel_ba` is 0, `a_out` equals the bit-wise inverse of `b_in`.
- R6: While `sel_ba` is 1, `a_out` equals the bit-wise inverse of the B-to-A register.
- R7: `b_oe` is 1 exactly when `en_b` is 1 (active-high enable for the B bus).
- R8: `a_oe` is 1 exactly when `en_a_n` is 0 (active-low enable for the A bus).
- R9: With `en_b`=1, `en_a_n`=0 and both selects at 1, both buses are driven in the same cycle. B carries the inverse of the held A word and A carries the inverse of the held B word.
- R10: `rst` is synchronous and active high, and it is sampled separately by each clock. A `clk_ab` edge with `rst` high clears only the A-to-B register, and a `clk_ba` edge with `rst` high clears only the B-to-A register. A cleared register with its select at 1 gives an output of all ones.
- R11: A `clk_ba` edge leaves the A-to-B register unchanged, and a `clk_ab` edge leaves the B-to-A register unchanged.
- R12: When both clocks rise in the same cycle with both selects at 0, each register loads its own bus input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high clear, seen by each clock |
| en_b | input | 1 | Drive enable for bus B, active high |
| en_a_n | input | 1 | Drive enable for bus A, active low |
| sel_ab | input | 1 | B-side source: 0 live A, 1 held A |
| sel_ba | input | 1 | A-side source: 0 live B, 1 held B |
| a_in | input | 8 | Value present on bus A |
| a_out | output | 8 | Data to drive onto bus A |
| a_oe | output | 1 | Drive enable for the bus A pad |
| b_in | input | 8 | Value present on bus B |
| b_out | output | 8 | Data to drive onto bus B |
| b_oe | output | 1 | Drive enable for the bus B pad |

## Verification
The held-path properties assume that every capture edge sees bus inputs and a reset level that settled before the edge. They also assume that each register has been cleared by at least one edge of its own clock while reset was high. To stay within these limits, the stimulus changes data, selects and enables only on the falling edge of the bench's reference clock. Each capture clock rises on a rising edge half a period later. The opening reset step pulses both capture clocks. When a stored word is routed across, the two clocks are fired in separate cycles so that each register loads a settled value.

// File: rtl/xbr_pkg.sv
package xbr_pkg;

    localparam int XBR_W = 8;

    // Source picked by a direction's select pin
    typedef enum logic {
        SRC_LIVE = 1'b0,
        SRC_HELD = 1'b1
    } src_e;

    // Polarity of a drive-enable pin
    typedef enum logic {
        OE_HIGH_TRUE = 1'b0,
        OE_LOW_TRUE  = 1'b1
    } oe_pol_e;

    function automatic logic oe_decode(input logic pin, input oe_pol_e pol);
        return (pol == OE_LOW_TRUE) ? ~pin : pin;
    endfunction

endpackage

// File: rtl/xbr_hold_reg.sv
module xbr_hold_reg #(
    parameter int W = xbr_pkg::XBR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Loads on every edge; no enable by design
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/xbr_lane.sv
module xbr_lane #(
    parameter int               W   = xbr_pkg::XBR_W,
    parameter xbr_pkg::oe_pol_e POL = xbr_pkg::OE_HIGH_TRUE
) (
    input  logic         cap_clk,
    input  logic         rst,
    input  logic [W-1:0] src_bus,
    input  logic         sel,
    input  logic         en_pin,
    output logic [W-1:0] drv,
    output logic         oe
);

    logic [W-1:0]  held;
    logic [W-1:0]  pick;
    xbr_pkg::src_e src;

    xbr_hold_reg #(.W(W)) u_hold (
        .clk (cap_clk),
        .rst (rst),
        .d   (src_bus),
        .q   (held)
    );

    assign src = xbr_pkg::src_e'(sel);

    always_comb begin
        unique case (src)
            xbr_pkg::SRC_HELD: pick = held;
            default:           pick = src_bus;
        endcase
    end

    assign drv = ~pick;
    assign oe  = xbr_pkg::oe_decode(en_pin, POL);

endmodule

// File: rtl/xbus_regxcvr.sv
module xbus_regxcvr #(
    parameter int W = xbr_pkg::XBR_W
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         rst,
    input  logic         en_b,
    input  logic         en_a_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    // A side feeds bus B
    xbr_lane #(.W(W), .POL(xbr_pkg::OE_HIGH_TRUE)) u_lane_ab (
        .cap_clk (clk_ab),
        .rst     (rst),
        .src_bus (a_in),
        .sel     (sel_ab),
        .en_pin  (en_b),
        .drv     (b_out),
        .oe      (b_oe)
    );

    // B side feeds bus A
    xbr_lane #(.W(W), .POL(xbr_pkg::OE_LOW_TRUE)) u_lane_ba (
        .cap_clk (clk_ba),
        .rst     (rst),
        .src_bus (b_in),
        .sel     (sel_ba),
        .en_pin  (en_a_n),
        .drv     (a_out),
        .oe      (a_oe)
    );

endmodule

// File: rtl/xbr_checker.sv
module xbr_checker #(
    parameter int W = xbr_pkg::XBR_W
) (
    input logic         clk_ab,
    input logic         clk_ba,
    input logic         rst,
    input logic         en_b,
    input logic         en_a_n,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic         a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic         b_oe
);

    logic [W-1:0] sh_ab;
    logic [W-1:0] sh_ba;

    always_ff @(posedge clk_ab) begin
        if (rst) sh_ab <= '0;
        else     sh_ab <= a_in;
    end

    always_ff @(posedge clk_ba) begin
        if (rst) sh_ba <= '0;
        else     sh_ba <= b_in;
    end

    AST_AB_HELD_ROUTE: assert property (@(posedge clk_ab) disable iff (rst) sel_ab |-> b_out == ~sh_ab); // R4
    AST_BA_HELD_ROUTE: assert property (@(posedge clk_ba) disable iff (rst) sel_ba |-> a_out == ~sh_ba); // R6
    AST_AB_LIVE_ROUTE: assert property (@(posedge clk_ab) disable iff (rst) !sel_ab |-> b_out == ~a_in); // R3
    AST_BA_LIVE_ROUTE: assert property (@(posedge clk_ba) disable iff (rst) !sel_ba |-> a_out == ~b_in); // R5
    AST_DUAL_DRIVE:    assert property (@(posedge clk_ab) disable iff (rst) (en_b && !en_a_n) |-> (a_oe && b_oe)); // R9
    AST_ISOLATED:      assert property (@(posedge clk_ba) disable iff (rst) (!en_b && en_a_n) |-> !(a_oe || b_oe)); // R7
    AST_A_OE_POLARITY: assert property (@(posedge clk_ab) disable iff (rst) a_oe != en_a_n); // R8

endmodule

bind xbus_regxcvr xbr_checker #(.W(W)) chk_i (
    .clk_ab (clk_ab),
    .clk_ba (clk_ba),
    .rst    (rst),
    .en_b   (en_b),
    .en_a_n (en_a_n),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .a_in   (a_in),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_in   (b_in),
    .b_out  (b_out),
    .b_oe   (b_oe)
);

// File: tb/xbus_regxcvr_tb_top.sv
module xbus_regxcvr_tb_top;

    localparam int W = 8;

    typedef struct {
        logic [W-1:0] a_out;
        logic         a_oe;
        logic [W-1:0] b_out;
        logic         b_oe;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic clk_ab = 1'b0, clk_ba = 1'b0, rst = 1'b1;
    logic en_b = 1'b0, en_a_n = 1'b1, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic a_oe, b_oe;

    logic [W-1:0] mdl_ab = '0, mdl_ba = '0;
    exp_t sb_q[$];
    int n_chk = 0, n_bad = 0, wd = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xbus_regxcvr #(.W(W)) dut_i (
        .clk_ab (clk_ab), .clk_ba (clk_ba), .rst (rst),
        .en_b (en_b), .en_a_n (en_a_n), .sel_ab (sel_ab), .sel_ba (sel_ba),
        .a_in (a_in), .a_out (a_out), .a_oe (a_oe),
        .b_in (b_in), .b_out (b_out), .b_oe (b_oe)
    );

    task automatic step(input logic r, input logic eb, input logic ean,
                        input logic sab, input logic sba,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit pab, input bit pba, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; en_b = eb; en_a_n = ean; sel_ab = sab; sel_ba = sba;
        a_in = a; b_in = b;
        @(posedge clk);
        clk_ab = pab; clk_ba = pba;
        if (pab) mdl_ab = r ? '0 : a;
        if (pba) mdl_ba = r ? '0 : b;
        @(negedge clk);
        clk_ab = 1'b0; clk_ba = 1'b0;
        e.b_out = ~(sab ? mdl_ab : a);
        e.a_out = ~(sba ? mdl_ba : b);
        e.b_oe  = eb;
        e.a_oe  = ~ean;
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: pops each expected item and compares it with the ports
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_chk++;
                if (a_out !== e.a_out || a_oe !== e.a_oe || b_out !== e.b_out || b_oe !== e.b_oe) begin
                    n_bad++;
                    $display("FAIL %s: actual a_out=%h a_oe=%b b_out=%h b_oe=%b expected a_out=%h a_oe=%b b_out=%h b_oe=%b",
                             e.tag, a_out, a_oe, b_out, b_oe, e.a_out, e.a_oe, e.b_out, e.b_oe);
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 5000 && !done) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin
        // R10: reset both registers, then read the cleared held words
        step(1, 0, 1, 1, 1, 8'h77, 8'h99, 1, 1, "R10 reset both clocks");
        step(0, 1, 0, 1, 1, 8'h12, 8'h34, 0, 0, "R10 cleared held = ones");
        // R3/R5 live paths
        step(0, 1, 0, 0, 0, 8'h5A, 8'hC3, 0, 0, "R3 R5 live inverse");
        // R1 capture while isolated; R4 held route
        step(0, 0, 1, 1, 1, 8'h3C, 8'h00, 1, 0, "R1 capture while isolated");
        step(0, 1, 0, 1, 1, 8'hFF, 8'h00, 0, 0, "R4 held A to B");
        // R11: clk_ba edge must not touch A-to-B register
        step(0, 1, 0, 1, 0, 8'hA0, 8'h81, 0, 1, "R11 clk_ba leaves AB reg");
        step(0, 1, 0, 1, 1, 8'h0F, 8'h11, 1, 0, "R11 clk_ab leaves BA reg");
        // R2/R6
        step(0, 0, 0, 1, 1, 8'h00, 8'hE7, 0, 1, "R2 capture B");
        step(0, 1, 1, 1, 1, 8'h55, 8'h55, 0, 0, "R6 held B to A");
        // R12 simultaneous clocks with live selects
        step(0, 1, 0, 0, 0, 8'h6B, 8'h94, 1, 1, "R12 both clocks same cycle");
        step(0, 1, 0, 1, 1, 8'h00, 8'h00, 0, 0, "R12 both loaded");
        // R9 dual drive of held words
        step(0, 1, 0, 1, 1, 8'hC8, 8'h2D, 0, 0, "R9 swap held words");
        // R1: capture the value the block drives onto A
        step(0, 0, 0, 0, 0, ~8'h4E, 8'h4E, 1, 0, "R1 capture driven A bus");
        step(0, 1, 0, 1, 0, 8'h00, 8'h4E, 0, 0, "R1 driven value held");
        // R10 mid-run reset only in the A-to-B domain
        step(1, 1, 0, 1, 1, 8'hAA, 8'hBB, 1, 0, "R10 reset AB only");
        step(0, 1, 0, 1, 1, 8'h01, 8'h02, 0, 0, "R10 BA reg kept");
        // R7/R8 sweep of every enable and select combination
        for (int k = 0; k < 16; k++) begin
            logic [3:0] c;
            c = 4'(k);
            step(0, c[3], c[2], c[1], c[0], 8'(k * 37 + 5), 8'(k * 91 + 3),
                 c[0], c[1], "R7 R8 R3 R4 R5 R6 sweep");
        end
        @(negedge clk);
        #4;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule